// File: doc/BRIEF.md
# Sub-array power gating controller for a reconfigurable fixed-width multiplier

This block manages power for a pipelined multiplier whose partial-product array is split into three sub-arrays. The sub-arrays are named here by the operand halves they combine: HL (upper X half times lower Y half), LH (lower X half times upper Y half) and HH (both upper halves). The multiplier runs in one of four modes: a full-width fixed-width product, two independent half-width fixed-width products, one half-width full-precision product, and two quarter-width full-precision products. For every operation the controller decides which sub-arrays must capture new operands. It produces a synchronous register enable for each sub-array's private input register and for the input register of the partial-sum adder. It also decides whether the final adder's second input is passed through or forced to zero.

A sub-array that is switched off does not produce zero. Some of its partial products are inverted, so it would have produced a fixed bit pattern. The controller therefore also supplies that pattern and a select that substitutes it, one pipeline stage after the enable. The pattern for HH and LH is a constant. The pattern for HL depends on the corner partial product of the lower halves and on the compensation flag of LH. That flag counts as set whenever LH is switched off. The corner value is carried along with the operation, so the substitute stays stable while HL is held.

The mode and the operands are presented on the ports each cycle. The sub-array enables come out one cycle later, aligned with the edge that loads the sub-array input registers. The substitute selects, the HL pattern and the adder enable come out two cycles later. The zero gate of the final adder comes out three cycles later.

Top module: `mgate_ctrl`

## Requirements
- R1: While reset is high, every enable, every select and the final-adder pass bit are 0, and the HL substitute reads 6'b010001.
- R2: With mode code 1 (two half-width fixed-width products), one cycle later HL and LH are enabled and HH is disabled, whatever the operands are.
- R3: With mode code 2 (half-width full precision) or 3 (two quarter-width products), one cycle later HH is enabled and HL and LH are disabled, whatever the operands are.
- R4: With mode code 0 (full-width fixed-width), an all-zero upper X half disables HL and HH, a zero lower X half disables LH, a zero upper Y half disables LH and HH, and a zero lower Y half disables HL. Each result appears one cycle later.
- R5: With mode code 0 and all four operand halves nonzero, all three sub-arrays are enabled one cycle later.
- R6: Two cycles after an operation, each substitute select is 1 exactly when that operation disabled the matching sub-array.
- R7: The HH substitute is 9'b111100000 and the LH substitute is 6'b001111 at all times.
- R8: Two cycles after an operation, the HL substitute is 6'b010001 when the corner input is 0, the LH flag input is 0 and LH is enabled. In every other case it is 6'b010010.
- R9: The partial-sum adder enable is 1 two cycles after a mode 0 operation and 0 two cycles after any other mode.
- R10: The final-adder pass bit is 1 three cycles after a mode 0 operation and 0 three cycles after any other mode, so its second input is held at zero in the other modes.
- R11: Operations issued on consecutive cycles, with arbitrary mode changes, each get their own outputs at their own offsets, with no mixing between neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Mode code: 0 full-width fixed, 1 dual half fixed, 2 half full-precision, 3 dual quarter |
| x_i | input | W | X operand |
| y_i | input | W | Y operand |
| pp_corner_i | input | 1 | Corner partial product of the lower halves (top bit of lower X AND top bit of lower Y) |
| lh_flag_i | input | 1 | Compensation flag produced by the LH sub-array |
| en_hl_o | output | 1 | Input register enable of HL |
| en_lh_o | output | 1 | Input register enable of LH |
| en_hh_o | output | 1 | Input register enable of HH |
| sel_hl_o | output | 1 | Substitute the HL pattern |
| sel_lh_o | output | 1 | Substitute the LH pattern |
| sel_hh_o | output | 1 | Substitute the HH pattern |
| sub_hl_o | output | W/2+2 | HL substitute pattern |
| sub_lh_o | output | W/2+2 | LH substitute pattern |
| sub_hh_o | output | W+1 | HH substitute pattern |
| sum_en_o | output | 1 | Input register enable of the partial-sum adder |
| fold_pass_o | output | 1 | 1 passes the final adder's second input, 0 forces it to zero |

## Verification
The assertions watch, on every cycle, the mode-only enable patterns and the zero-half rules of the full-width mode. They also check that each select is the inverse of the enable one cycle earlier, the adder enable and pass bit at their offsets, and the forced HL pattern when LH is off. Only the bench scenarios can show the exact HL pattern for each combination of corner bit, flag and LH enable, the constant substitutes, the reset values seen from the ports, and that a long stream of mixed modes with zero halves keeps every operation's outputs in its own slot.

// File: rtl/mgate_pkg.sv
package mgate_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE  = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_HALF  = 2'd2,
    MODE_QUAD  = 2'd3
  } mode_e;

  typedef struct packed {
    logic hl;
    logic lh;
    logic hh;
  } arr_en_t;
endpackage

// File: rtl/mgate_nib_zero.sv
module mgate_nib_zero #(
  parameter int NW = 4
) (
  input  logic [NW-1:0] nib_i,
  output logic          zero_o
);
  assign zero_o = (nib_i == '0);
endmodule

// File: rtl/mgate_decode.sv
module mgate_decode
  import mgate_pkg::*;
(
  input  mode_e   mode_i,
  input  logic    xh_z_i,
  input  logic    xl_z_i,
  input  logic    yh_z_i,
  input  logic    yl_z_i,
  output arr_en_t run_o,
  output logic    sum_o
);
  always_comb begin
    unique case (mode_i)
      MODE_WIDE: begin
        run_o.hl = !xh_z_i && !yl_z_i;
        run_o.lh = !xl_z_i && !yh_z_i;
        run_o.hh = !xh_z_i && !yh_z_i;
        sum_o    = 1'b1;
      end
      MODE_SPLIT: begin
        run_o = '{hl: 1'b1, lh: 1'b1, hh: 1'b0};
        sum_o = 1'b0;
      end
      default: begin
        run_o = '{hl: 1'b0, lh: 1'b0, hh: 1'b1};
        sum_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mgate_pipe.sv
module mgate_pipe #(
  parameter int            DW = 1,
  parameter logic [DW-1:0] RV = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= RV;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/mgate_ctrl.sv
module mgate_ctrl
  import mgate_pkg::*;
#(
  parameter int             W           = 8,
  parameter logic [W:0]     SUB_HH      = 9'b111100000,
  parameter logic [W/2+1:0] SUB_LH      = 6'b001111,
  parameter logic [W/2+1:0] SUB_HL_BASE = 6'b010000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  logic           pp_corner_i,
  input  logic           lh_flag_i,
  output logic           en_hl_o,
  output logic           en_lh_o,
  output logic           en_hh_o,
  output logic           sel_hl_o,
  output logic           sel_lh_o,
  output logic           sel_hh_o,
  output logic [W/2+1:0] sub_hl_o,
  output logic [W/2+1:0] sub_lh_o,
  output logic [W:0]     sub_hh_o,
  output logic           sum_en_o,
  output logic           fold_pass_o
);
  localparam int H  = W / 2;
  localparam int SW = 5;  // three enables, adder flag, corner bit

  // halves in order: 0 x low, 1 x high, 2 y low, 3 y high
  logic [3:0][H-1:0] halves;
  logic [3:0]        zf;
  assign halves = {y_i[W-1:H], y_i[H-1:0], x_i[W-1:H], x_i[H-1:0]};

  for (genvar k = 0; k < 4; k++) begin : g_zero
    mgate_nib_zero #(.NW(H)) u_z (.nib_i(halves[k]), .zero_o(zf[k]));
  end

  arr_en_t run;
  logic    sum_on;

  mgate_decode u_dec (
    .mode_i (mode_e'(mode_i)),
    .xh_z_i (zf[1]),
    .xl_z_i (zf[0]),
    .yh_z_i (zf[3]),
    .yl_z_i (zf[2]),
    .run_o  (run),
    .sum_o  (sum_on)
  );

  // LH compensation flag counts as set when LH is held
  logic corner;
  assign corner = pp_corner_i | lh_flag_i | !run.lh;

  logic [SW-1:0] s1_d, s1_q, s2_d, s2_q;
  logic          s3_q;

  assign s1_d = {run.hl, run.lh, run.hh, sum_on, corner};
  mgate_pipe #(.DW(SW)) u_s1 (.clk(clk), .rst(rst), .d_i(s1_d), .q_o(s1_q));

  assign s2_d = {~s1_q[4:2], s1_q[1], s1_q[0]};
  mgate_pipe #(.DW(SW)) u_s2 (.clk(clk), .rst(rst), .d_i(s2_d), .q_o(s2_q));

  mgate_pipe #(.DW(1)) u_s3 (.clk(clk), .rst(rst), .d_i(s2_q[1]), .q_o(s3_q));

  assign {en_hl_o, en_lh_o, en_hh_o}    = s1_q[4:2];
  assign {sel_hl_o, sel_lh_o, sel_hh_o} = s2_q[4:2];
  assign sum_en_o    = s2_q[1];
  assign sub_hl_o    = SUB_HL_BASE | {{H{1'b0}}, s2_q[0], ~s2_q[0]};
  assign sub_lh_o    = SUB_LH;
  assign sub_hh_o    = SUB_HH;
  assign fold_pass_o = s3_q;
endmodule

// File: rtl/mgate_ctrl_chk.sv
module mgate_ctrl_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     mode_i,
  input logic [W-1:0]   x_i,
  input logic [W-1:0]   y_i,
  input logic           en_hl_o,
  input logic           en_lh_o,
  input logic           en_hh_o,
  input logic           sel_hl_o,
  input logic           sel_lh_o,
  input logic           sel_hh_o,
  input logic [W/2+1:0] sub_hl_o,
  input logic           sum_en_o,
  input logic           fold_pass_o
);
  localparam int H = W / 2;

  assert_split_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1) |=> (en_hl_o && en_lh_o && !en_hh_o));

  assert_narrow_R3: assert property (@(posedge clk) disable iff (rst)
    mode_i[1] |=> (!en_hl_o && !en_lh_o && en_hh_o));

  assert_xhi_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 && x_i[W-1:H] == '0) |=> (!en_hl_o && !en_hh_o));

  assert_yhi_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 && y_i[W-1:H] == '0) |=> (!en_lh_o && !en_hh_o));

  assert_all_on_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 && x_i[W-1:H] != '0 && x_i[H-1:0] != '0 &&
     y_i[W-1:H] != '0 && y_i[H-1:0] != '0) |=> (en_hl_o && en_lh_o && en_hh_o));

  assert_sel_follows_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sel_hl_o == !$past(en_hl_o) && sel_lh_o == !$past(en_lh_o) &&
                     sel_hh_o == !$past(en_hh_o)));

  assert_hl_forced_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 && y_i[W-1:H] == '0) |=> ##1 (sub_hl_o[1:0] == 2'b10));

  assert_sum_on_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0) |=> ##1 sum_en_o);

  assert_sum_off_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'd0) |=> ##1 !sum_en_o);

  assert_fold_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0) |=> ##2 fold_pass_o);

  assert_fold_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'd0) |=> ##2 !fold_pass_o);
endmodule

bind mgate_ctrl mgate_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .x_i(x_i), .y_i(y_i),
  .en_hl_o(en_hl_o), .en_lh_o(en_lh_o), .en_hh_o(en_hh_o),
  .sel_hl_o(sel_hl_o), .sel_lh_o(sel_lh_o), .sel_hh_o(sel_hh_o),
  .sub_hl_o(sub_hl_o), .sum_en_o(sum_en_o), .fold_pass_o(fold_pass_o)
);

// File: tb/mgate_ctrl_test.sv
`timescale 1ns/1ps
module mgate_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [7:0] x = 8'd0, y = 8'd0;
  logic       corner = 1'b0, flag = 1'b0;

  logic       en_hl, en_lh, en_hh, sel_hl, sel_lh, sel_hh, sum_en, fold;
  logic [5:0] sub_hl, sub_lh;
  logic [8:0] sub_hh;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mgate_ctrl uut (
    .clk(clk), .rst(rst), .mode_i(mode), .x_i(x), .y_i(y),
    .pp_corner_i(corner), .lh_flag_i(flag),
    .en_hl_o(en_hl), .en_lh_o(en_lh), .en_hh_o(en_hh),
    .sel_hl_o(sel_hl), .sel_lh_o(sel_lh), .sel_hh_o(sel_hh),
    .sub_hl_o(sub_hl), .sub_lh_o(sub_lh), .sub_hh_o(sub_hh),
    .sum_en_o(sum_en), .fold_pass_o(fold)
  );

  // expected-value history: slot 1 = op issued one step ago, etc.
  logic       v1 = 0, v2 = 0, v3 = 0;
  logic [2:0] e1_en, e2_en;
  logic       e1_sum, e2_sum, e3_sum;
  logic [5:0] e1_sub, e2_sub;
  string      t1 = "";

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_en(input logic [1:0] m, input logic [7:0] a, input logic [7:0] b);
    logic xh, xl, yh, yl;
    xh = (a[7:4] != 0); xl = (a[3:0] != 0);
    yh = (b[7:4] != 0); yl = (b[3:0] != 0);
    case (m)
      2'd0:    return {xh && yl, xl && yh, xh && yh};
      2'd1:    return 3'b110;
      default: return 3'b001;
    endcase
  endfunction

  task automatic step(input logic [1:0] m, input logic [7:0] a, input logic [7:0] b,
                      input logic c, input logic k, input string tag);
    logic [2:0] en;
    if (v1) chk({t1, " enables"}, {13'd0, en_hl, en_lh, en_hh}, {13'd0, e1_en});
    if (v2) begin
      chk("R6 selects", {13'd0, sel_hl, sel_lh, sel_hh}, {13'd0, ~e2_en});
      chk("R9 sum enable", {15'd0, sum_en}, {15'd0, e2_sum});
      chk("R8 hl substitute", {10'd0, sub_hl}, {10'd0, e2_sub});
    end
    if (v3) chk("R10 fold pass", {15'd0, fold}, {15'd0, e3_sum});
    v3 = v2; e3_sum = e2_sum;
    v2 = v1; e2_sum = e1_sum; e2_en = e1_en; e2_sub = e1_sub;
    en = exp_en(m, a, b);
    v1 = 1; e1_en = en; e1_sum = (m == 2'd0); t1 = tag;
    e1_sub = (c | k | !en[1]) ? 6'b010010 : 6'b010001;
    mode = m; x = a; y = b; corner = c; flag = k;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(2'd1, 8'h11, 8'h11, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    mode = 2'd0; x = 8'hFF; y = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 enables", {13'd0, en_hl, en_lh, en_hh}, 16'd0);
    chk("R1 selects", {13'd0, sel_hl, sel_lh, sel_hh}, 16'd0);
    chk("R1 sum/fold", {14'd0, sum_en, fold}, 16'd0);
    chk("R1 hl substitute", {10'd0, sub_hl}, 16'h0011);
    v1 = 0; v2 = 0; v3 = 0;
    rst = 1'b0;
  endtask

  task automatic t_consts();
    chk("R7 hh constant", {7'd0, sub_hh}, 16'h01E0);
    chk("R7 lh constant", {10'd0, sub_lh}, 16'h000F);
  endtask

  task automatic t_split();
    step(2'd1, 8'h00, 8'h00, 1'b0, 1'b0, "R2");
    step(2'd1, 8'hA5, 8'h3C, 1'b1, 1'b0, "R2");
    step(2'd1, 8'h0F, 8'hF0, 1'b0, 1'b1, "R2");
    drain();
  endtask

  task automatic t_narrow();
    step(2'd2, 8'h00, 8'h12, 1'b0, 1'b0, "R3");
    step(2'd3, 8'h34, 8'h00, 1'b1, 1'b1, "R3");
    step(2'd2, 8'hFF, 8'hFF, 1'b0, 1'b1, "R3");
    step(2'd3, 8'h81, 8'h18, 1'b0, 1'b0, "R3");
    drain();
  endtask

  task automatic t_zero_halves();
    step(2'd0, 8'h05, 8'h55, 1'b0, 1'b0, "R4 x hi zero");
    step(2'd0, 8'h50, 8'h55, 1'b0, 1'b0, "R4 x lo zero");
    step(2'd0, 8'h55, 8'h05, 1'b0, 1'b0, "R4 y hi zero");
    step(2'd0, 8'h55, 8'h50, 1'b0, 1'b0, "R4 y lo zero");
    step(2'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R4 all zero");
    step(2'd0, 8'h80, 8'h01, 1'b1, 1'b0, "R4 cross");
    drain();
  endtask

  task automatic t_all_on();
    step(2'd0, 8'h11, 8'h11, 1'b0, 1'b0, "R5");
    step(2'd0, 8'hFF, 8'h9A, 1'b1, 1'b0, "R5");
    step(2'd0, 8'h7E, 8'h1F, 1'b0, 1'b1, "R5");
    step(2'd0, 8'h7E, 8'h1F, 1'b1, 1'b1, "R5");
    drain();
  endtask

  task automatic t_stream();
    logic [15:0] lf = 16'hACE1;
    logic [7:0]  a, b;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = lf[7:0]; b = {lf[3:0], lf[15:12]};
      if (lf[8])  a[7:4] = 4'd0;
      if (lf[9])  b[3:0] = 4'd0;
      if (lf[10]) b[7:4] = 4'd0;
      if (lf[11] && lf[6]) a[3:0] = 4'd0;
      step(lf[13:12], a, b, lf[5], lf[14], "R11");
    end
    drain();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_consts();
    t_split();
    t_narrow();
    t_zero_halves();
    t_all_on();
    t_stream();
    t_reset();
    t_consts();
    t_zero_halves();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule